// File: doc/BRIEF.md
# Endpoint Double-Buffer RAM Access Engine

This block carries endpoint payload bytes between a USB serial engine and a single-port RAM that is shared with the CPU. Each endpoint owns a window in that RAM. The window starts at a programmable base address and holds one or two packet-sized halves. A received byte is written straight to RAM, and a byte needed for transmission is read straight from RAM. The CPU takes no part in either transfer. The engine keeps the byte count, hands a completed half to the CPU and flags an interrupt.

Every RAM access is raised as a request to an external arbiter. It is held steady until a grant arrives without a wait. The USB side delivers one byte every few clocks, so the engine keeps a single access in flight. A byte that arrives while the previous access is still open is reported through a sticky error flag.

In ping-pong mode, one half can fill while the CPU drains the other. Each half alternates between USB ownership and CPU ownership. A transaction that finds its current half owned by the CPU is refused with a NAK.

Top module: `ep_buffer_engine`

## Requirements
- R1: After reset: ram_req and irq are low; every endpoint reads base 0, size 64, single-buffer mode; both halves are USB-owned; done, error and the current-half bit are 0.
- R2: An OUT byte is written to base + (current half ? size : 0) + byte index. ram_req, ram_addr, ram_we and ram_wdata hold until a cycle with ram_gnt high and ram_wait low, so one wait cycle loses no byte.
- R3: For an IN transaction, each usb_tx_req reads the next address of the half. usb_tx_valid rises with the RAM byte on usb_tx_data two cycles after the cycle in which the read was granted without wait.
- R4: A byte or read request that arrives while the previous access is still ungranted is dropped. It sets the endpoint's sticky error bit (control register bit 3). Writing 1 to control bit 3 clears the error bit.
- R5: A transaction that ends with usb_ok high makes its half CPU-owned. It stores the byte count in that half's count register (select 3 for half 0, select 4 for half 1), sets done (status bit 2) and drives irq high. irq is low when no endpoint has done set.
- R6: A packet shorter than the size records its own length. Bytes beyond the size are neither written nor counted and do not set the error bit.
- R7: In double-buffer mode (size register bit 7), each successful transaction toggles the current half (status bit 4). In single-buffer mode only half 0 is used.
- R8: A transaction that ends with usb_ok low leaves ownership, the current half, done and the count registers unchanged.
- R9: usb_start on an endpoint whose current half is CPU-owned pulses usb_nak for one cycle, one cycle later. The rejected transaction makes no RAM access.
- R10: Writing 1 to control bit 0 or 1 returns half 0 or half 1 to USB ownership. Writing 1 to bit 2 clears done. If a completion and a clear-done write reach the same endpoint in the same cycle, done is set.
- R11: The register addressed on cfg_addr ({endpoint, select}) appears on cfg_rdata one cycle later. Select 0 is the base, select 1 is the size in bits 6:0 and the mode in bit 7, and select 2 is status, with bit 0 and bit 1 as half ownership (1 = USB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | CPU register write strobe |
| cfg_addr | input | EP_W+3 | Endpoint number over 3-bit register select |
| cfg_wdata | input | 16 | CPU write data |
| cfg_rdata | output | 16 | Registered read data |
| usb_start | input | 1 | Start of a data transaction |
| usb_ep | input | EP_W | Endpoint of the starting transaction |
| usb_dir | input | 1 | 0 = OUT (to RAM), 1 = IN (from RAM) |
| usb_nak | output | 1 | Transaction refused, current half CPU-owned |
| usb_rx_valid | input | 1 | Received byte strobe |
| usb_rx_data | input | 8 | Received byte |
| usb_tx_req | input | 1 | Next transmit byte wanted |
| usb_tx_valid | output | 1 | Transmit byte valid |
| usb_tx_data | output | 8 | Transmit byte |
| usb_end | input | 1 | End of transaction |
| usb_ok | input | 1 | Transaction succeeded (qualifies usb_end) |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_gnt | input | 1 | Arbiter grant |
| ram_wait | input | 1 | One-cycle access extension |
| ram_rdata | input | 8 | RAM read data, valid the cycle after a read access |
| irq | output | 1 | Completion interrupt |

## Verification
The case that needs care is a USB completion that sets an endpoint's done flag in the same cycle that the CPU writes a clear-done to that endpoint. The bench times a clear-done write so that it lands exactly in the cycle that carries the registered completion event. It then requires the done flag and irq to remain set. A second overlap is a new received byte that arrives while the arbiter is still withholding the grant for the previous one. Here the bench requires that the older byte is written, the newer one is dropped and counted nowhere, and the error flag goes up.

// File: rtl/ep_buffer_pkg.sv
package ep_buffer_pkg;
  localparam int CFG_DW = 16;

  typedef enum logic [2:0] {
    SEL_BASE = 3'd0,
    SEL_SIZE = 3'd1,
    SEL_CTRL = 3'd2,
    SEL_CNT0 = 3'd3,
    SEL_CNT1 = 3'd4
  } reg_sel_e;

  localparam int CTL_REL0     = 0;
  localparam int CTL_REL1     = 1;
  localparam int CTL_CLR_DONE = 2;
  localparam int CTL_CLR_ERR  = 3;
  localparam int ST_CUR       = 4;
  localparam int SIZE_DBL     = 7;
endpackage

// File: rtl/ep_buffer_regs.sv
module ep_buffer_regs
  import ep_buffer_pkg::*;
#(
  parameter int NUM_EP  = 4,
  parameter int ADDR_W  = 10,
  parameter int PKT_MAX = 64,
  parameter int CNT_W   = 7,
  parameter int EP_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [EP_W+2:0]   cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic [EP_W-1:0]   look_ep,
  output logic [ADDR_W-1:0] look_base,
  output logic [CNT_W-1:0]  look_size,
  output logic              look_cur,
  output logic              look_avail,
  input  logic              cmp_vld,
  input  logic [EP_W-1:0]   cmp_ep,
  input  logic              cmp_half,
  input  logic [CNT_W-1:0]  cmp_cnt,
  input  logic              err_vld,
  input  logic [EP_W-1:0]   err_ep,
  output logic              irq
);
  logic [ADDR_W-1:0] base_a [NUM_EP];
  logic [CNT_W-1:0]  size_a [NUM_EP];
  logic [CNT_W-1:0]  c0_a   [NUM_EP];
  logic [CNT_W-1:0]  c1_a   [NUM_EP];
  logic [1:0]        own_a  [NUM_EP];
  logic [NUM_EP-1:0] dbl_a, cur_a, done_a, err_a;

  logic [EP_W-1:0] wr_ep;
  logic [2:0]      wr_sel;
  logic            unused_wd;
  assign wr_ep     = cfg_addr[EP_W+2:3];
  assign wr_sel    = cfg_addr[2:0];
  assign unused_wd = ^cfg_wdata;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic [ADDR_W-1:0] base_r;
    logic [CNT_W-1:0]  size_r, c0_r, c1_r;
    logic [1:0]        own_r;
    logic              dbl_r, cur_r, done_r, err_r;
    logic              wr_me, cmp_me, err_me;

    assign wr_me  = cfg_we && (wr_ep == EP_W'(e));
    assign cmp_me = cmp_vld && (cmp_ep == EP_W'(e));
    assign err_me = err_vld && (err_ep == EP_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_r <= '0;
        size_r <= CNT_W'(PKT_MAX);
        dbl_r  <= 1'b0;
        own_r  <= 2'b11;
        cur_r  <= 1'b0;
        done_r <= 1'b0;
        err_r  <= 1'b0;
        c0_r   <= '0;
        c1_r   <= '0;
      end else begin
        if (wr_me && wr_sel == SEL_BASE) base_r <= cfg_wdata[ADDR_W-1:0];
        if (wr_me && wr_sel == SEL_SIZE) begin
          size_r <= cfg_wdata[CNT_W-1:0];
          dbl_r  <= cfg_wdata[SIZE_DBL];
          if (!cfg_wdata[SIZE_DBL]) cur_r <= 1'b0;
        end
        if (wr_me && wr_sel == SEL_CTRL) begin
          own_r <= own_r | cfg_wdata[CTL_REL1:CTL_REL0];
          if (cfg_wdata[CTL_CLR_DONE]) done_r <= 1'b0;
          if (cfg_wdata[CTL_CLR_ERR])  err_r  <= 1'b0;
        end
        if (err_me) err_r <= 1'b1;
        // completion is written last so that it wins over a CPU clear
        if (cmp_me) begin
          own_r[cmp_half] <= 1'b0;
          done_r          <= 1'b1;
          if (cmp_half) c1_r <= cmp_cnt;
          else          c0_r <= cmp_cnt;
          if (dbl_r) cur_r <= ~cmp_half;
        end
      end
    end

    assign base_a[e] = base_r;
    assign size_a[e] = size_r;
    assign c0_a[e]   = c0_r;
    assign c1_a[e]   = c1_r;
    assign own_a[e]  = own_r;
    assign dbl_a[e]  = dbl_r;
    assign cur_a[e]  = cur_r;
    assign done_a[e] = done_r;
    assign err_a[e]  = err_r;

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      err_r && !(wr_me && wr_sel == SEL_CTRL && cfg_wdata[CTL_CLR_ERR]) |=> err_r);
    // R7
    single_half_chk: assert property (@(posedge clk) disable iff (rst)
      !dbl_r |-> !cur_r);
  end

  assign look_base  = base_a[look_ep];
  assign look_size  = size_a[look_ep];
  assign look_cur   = cur_a[look_ep];
  assign look_avail = own_a[look_ep][cur_a[look_ep]];

  logic [CFG_DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (wr_sel)
      SEL_BASE: rd_next[ADDR_W-1:0] = base_a[wr_ep];
      SEL_SIZE: begin
        rd_next[CNT_W-1:0] = size_a[wr_ep];
        rd_next[SIZE_DBL]  = dbl_a[wr_ep];
      end
      SEL_CTRL: begin
        rd_next[CTL_REL1:CTL_REL0] = own_a[wr_ep];
        rd_next[CTL_CLR_DONE]      = done_a[wr_ep];
        rd_next[CTL_CLR_ERR]       = err_a[wr_ep];
        rd_next[ST_CUR]            = cur_a[wr_ep];
      end
      SEL_CNT0: rd_next[CNT_W-1:0] = c0_a[wr_ep];
      SEL_CNT1: rd_next[CNT_W-1:0] = c1_a[wr_ep];
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      cfg_rdata <= rd_next;
      irq       <= |done_a;
    end
  end

  // R5
  cmp_done_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_vld |=> done_a[$past(cmp_ep)]);
  // R5
  cmp_own_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_vld |=> !own_a[$past(cmp_ep)][$past(cmp_half)]);
endmodule

// File: rtl/ep_buffer_xfer.sv
module ep_buffer_xfer
  import ep_buffer_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 7,
  parameter int EP_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usb_start,
  input  logic [EP_W-1:0]   usb_ep,
  input  logic              usb_dir,
  input  logic              usb_rx_valid,
  input  logic [7:0]        usb_rx_data,
  input  logic              usb_tx_req,
  input  logic              usb_end,
  input  logic              usb_ok,
  output logic              usb_nak,
  output logic              usb_tx_valid,
  output logic [7:0]        usb_tx_data,
  input  logic [ADDR_W-1:0] look_base,
  input  logic [CNT_W-1:0]  look_size,
  input  logic              look_cur,
  input  logic              look_avail,
  output logic              ram_req,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic              ram_gnt,
  input  logic              ram_wait,
  input  logic [7:0]        ram_rdata,
  output logic              cmp_vld,
  output logic [EP_W-1:0]   cmp_ep,
  output logic              cmp_half,
  output logic [CNT_W-1:0]  cmp_cnt,
  output logic              err_vld,
  output logic [EP_W-1:0]   err_ep
);
  logic              active, a_dir, a_half, rd_ret;
  logic [EP_W-1:0]   a_ep;
  logic [CNT_W-1:0]  a_max, cnt;
  logic [ADDR_W-1:0] ptr;

  logic acc_done, busy, byte_evt, room;
  assign acc_done = ram_req && ram_gnt && !ram_wait;
  assign busy     = ram_req && !acc_done;
  assign byte_evt = a_dir ? usb_tx_req : usb_rx_valid;
  assign room     = cnt < a_max;

  always_ff @(posedge clk) begin
    if (rst) begin
      active       <= 1'b0;
      a_dir        <= 1'b0;
      a_half       <= 1'b0;
      a_ep         <= '0;
      a_max        <= '0;
      cnt          <= '0;
      ptr          <= '0;
      ram_req      <= 1'b0;
      ram_we       <= 1'b0;
      ram_addr     <= '0;
      ram_wdata    <= '0;
      rd_ret       <= 1'b0;
      usb_tx_valid <= 1'b0;
      usb_tx_data  <= '0;
      usb_nak      <= 1'b0;
      cmp_vld      <= 1'b0;
      cmp_ep       <= '0;
      cmp_half     <= 1'b0;
      cmp_cnt      <= '0;
      err_vld      <= 1'b0;
      err_ep       <= '0;
    end else begin
      usb_nak      <= 1'b0;
      cmp_vld      <= 1'b0;
      err_vld      <= 1'b0;
      rd_ret       <= acc_done && !ram_we;
      usb_tx_valid <= rd_ret;
      if (rd_ret) usb_tx_data <= ram_rdata;
      if (acc_done) ram_req <= 1'b0;

      if (!active) begin
        if (usb_start) begin
          if (look_avail) begin
            active <= 1'b1;
            a_ep   <= usb_ep;
            a_dir  <= usb_dir;
            a_half <= look_cur;
            a_max  <= look_size;
            cnt    <= '0;
            ptr    <= look_base + (look_cur ? ADDR_W'(look_size) : '0);
          end else begin
            usb_nak <= 1'b1;
          end
        end
      end else if (usb_end) begin
        active <= 1'b0;
        if (usb_ok) begin
          cmp_vld  <= 1'b1;
          cmp_ep   <= a_ep;
          cmp_half <= a_half;
          cmp_cnt  <= cnt;
        end
      end else if (byte_evt && room) begin
        if (busy) begin
          err_vld <= 1'b1;
          err_ep  <= a_ep;
        end else begin
          ram_req   <= 1'b1;
          ram_we    <= !a_dir;
          ram_addr  <= ptr;
          ram_wdata <= usb_rx_data;
          ptr       <= ptr + 1'b1;
          cnt       <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ram_req && !(ram_gnt && !ram_wait) |=>
      ram_req && $stable(ram_addr) && $stable(ram_we) && $stable(ram_wdata));
  // R3
  tx_latency_chk: assert property (@(posedge clk) disable iff (rst)
    usb_tx_valid |-> $past(ram_req && ram_gnt && !ram_wait && !ram_we, 2));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> cnt <= a_max);
  // R9
  nak_cause_chk: assert property (@(posedge clk) disable iff (rst)
    usb_nak |-> $past(usb_start && !look_avail));
endmodule

// File: rtl/ep_buffer_engine.sv
module ep_buffer_engine
  import ep_buffer_pkg::*;
#(
  parameter int NUM_EP  = 4,
  parameter int ADDR_W  = 10,
  parameter int PKT_MAX = 64,
  localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int CNT_W  = $clog2(PKT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [EP_W+2:0]   cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              usb_start,
  input  logic [EP_W-1:0]   usb_ep,
  input  logic              usb_dir,
  output logic              usb_nak,
  input  logic              usb_rx_valid,
  input  logic [7:0]        usb_rx_data,
  input  logic              usb_tx_req,
  output logic              usb_tx_valid,
  output logic [7:0]        usb_tx_data,
  input  logic              usb_end,
  input  logic              usb_ok,
  output logic              ram_req,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic              ram_gnt,
  input  logic              ram_wait,
  input  logic [7:0]        ram_rdata,
  output logic              irq
);
  logic [ADDR_W-1:0] look_base;
  logic [CNT_W-1:0]  look_size, cmp_cnt;
  logic              look_cur, look_avail, cmp_vld, cmp_half, err_vld;
  logic [EP_W-1:0]   cmp_ep, err_ep;

  ep_buffer_regs #(
    .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .PKT_MAX(PKT_MAX), .CNT_W(CNT_W), .EP_W(EP_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .look_ep(usb_ep), .look_base(look_base), .look_size(look_size),
    .look_cur(look_cur), .look_avail(look_avail),
    .cmp_vld(cmp_vld), .cmp_ep(cmp_ep), .cmp_half(cmp_half), .cmp_cnt(cmp_cnt),
    .err_vld(err_vld), .err_ep(err_ep), .irq(irq)
  );

  ep_buffer_xfer #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .EP_W(EP_W)
  ) u_xfer (
    .clk(clk), .rst(rst),
    .usb_start(usb_start), .usb_ep(usb_ep), .usb_dir(usb_dir),
    .usb_rx_valid(usb_rx_valid), .usb_rx_data(usb_rx_data), .usb_tx_req(usb_tx_req),
    .usb_end(usb_end), .usb_ok(usb_ok), .usb_nak(usb_nak),
    .usb_tx_valid(usb_tx_valid), .usb_tx_data(usb_tx_data),
    .look_base(look_base), .look_size(look_size), .look_cur(look_cur), .look_avail(look_avail),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_gnt(ram_gnt), .ram_wait(ram_wait), .ram_rdata(ram_rdata),
    .cmp_vld(cmp_vld), .cmp_ep(cmp_ep), .cmp_half(cmp_half), .cmp_cnt(cmp_cnt),
    .err_vld(err_vld), .err_ep(err_ep)
  );
endmodule

// File: tb/sim_ep_buffer_engine.sv
module sim_ep_buffer_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, cfg_we, usb_start, usb_dir, usb_nak, usb_rx_valid, usb_tx_req;
  logic        usb_tx_valid, usb_end, usb_ok, ram_req, ram_we, ram_gnt, ram_wait, irq;
  logic [4:0]  cfg_addr;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic [1:0]  usb_ep;
  logic [7:0]  usb_rx_data, usb_tx_data, ram_wdata, ram_rdata;
  logic [9:0]  ram_addr;

  ep_buffer_engine u0 (.*);

  logic [7:0] mem [0:1023];
  logic [9:0] wr_log [0:1023];
  int wr_n = 0;
  always @(posedge clk) begin
    if (ram_req && ram_gnt && !ram_wait) begin
      if (ram_we) begin
        mem[ram_addr]  <= ram_wdata;
        wr_log[wr_n]   <= ram_addr;
        wr_n           <= wr_n + 1;
      end
      ram_rdata <= mem[ram_addr];
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int ep, input int sel, input logic [15:0] d);
    cfg_addr = {2'(ep), 3'(sel)}; cfg_wdata = d; cfg_we = 1'b1;
    tick(); cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input int ep, input int sel, output logic [15:0] d);
    cfg_addr = {2'(ep), 3'(sel)};
    tick(); d = cfg_rdata;
  endtask

  task automatic pkt_out(input int ep, input int nb, input logic ok, input int seed);
    usb_ep = 2'(ep); usb_dir = 1'b0; usb_start = 1'b1; tick(); usb_start = 1'b0; tick();
    for (int k = 0; k < nb; k++) begin
      usb_rx_valid = 1'b1; usb_rx_data = 8'(seed * 16 + k + 1); tick();
      usb_rx_valid = 1'b0; tick(4);
    end
    usb_end = 1'b1; usb_ok = ok; tick(); usb_end = 1'b0; tick(4);
  endtask

  typedef struct packed {
    logic [1:0] ep; logic [9:0] base; logic [6:0] size;
    logic dbl; logic [6:0] nb; logic ok;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{2'd0, 10'h010, 7'd8,  1'b0, 7'd8,  1'b1},
    '{2'd1, 10'h100, 7'd16, 1'b1, 7'd5,  1'b1},
    '{2'd1, 10'h100, 7'd16, 1'b1, 7'd16, 1'b1},
    '{2'd2, 10'h340, 7'd64, 1'b1, 7'd64, 1'b1},
    '{2'd3, 10'h200, 7'd4,  1'b0, 7'd6,  1'b1},
    '{2'd1, 10'h100, 7'd16, 1'b1, 7'd3,  1'b0}
  };

  logic       cur_m [4] = '{0, 0, 0, 0};
  logic [6:0] cnt_m [4][2];

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int start, nw, bad, h;
    logic [9:0] eb;
    for (int e = 0; e < 4; e++) begin cnt_m[e][0] = '0; cnt_m[e][1] = '0; end
    rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; usb_start = 0; usb_ep = 0;
    usb_dir = 0; usb_rx_valid = 0; usb_rx_data = 0; usb_tx_req = 0; usb_end = 0;
    usb_ok = 0; ram_gnt = 1; ram_wait = 0;
    tick(3); rst = 1'b0;

    // R1 reset state
    chk("R1 ram_req", ram_req, 0);
    chk("R1 irq", irq, 0);
    cfg_rd(2, 2, d); chk("R1 status", d, 16'h0003);
    cfg_rd(1, 0, d); chk("R1 base", d, 0);
    // R11 one-cycle read latency of size register
    cfg_rd(3, 1, d); chk("R11 size read", d, 16'h0040);

    // vector table: configure, send, judge
    for (int v = 0; v < 6; v++) begin
      cfg_wr(VEC[v].ep, 0, 16'(VEC[v].base));
      cfg_wr(VEC[v].ep, 1, {8'h0, VEC[v].dbl, VEC[v].size});
      h  = cur_m[VEC[v].ep];
      eb = VEC[v].base + (h ? 10'(VEC[v].size) : 10'd0);
      nw = (VEC[v].nb < VEC[v].size) ? VEC[v].nb : VEC[v].size;
      start = wr_n;
      pkt_out(VEC[v].ep, VEC[v].nb, VEC[v].ok, v);
      bad = 0;
      for (int k = 0; k < nw; k++) begin
        if (wr_log[start + k] !== 10'(eb + k)) bad++;
        if (mem[10'(eb + k)] !== 8'(v * 16 + k + 1)) bad++;
      end
      if (wr_n - start != nw) bad++;
      chk("R2 R6 write addresses and bytes", bad, 0);
      if (VEC[v].ok) begin
        cnt_m[VEC[v].ep][h] = 7'(nw);
        if (VEC[v].dbl) cur_m[VEC[v].ep] = ~cur_m[VEC[v].ep];
      end
      cfg_rd(VEC[v].ep, 3 + h, d);
      chk("R5 R6 R8 count register", d, 16'(cnt_m[VEC[v].ep][h]));
      cfg_rd(VEC[v].ep, 2, d);
      chk("R5 R7 R8 status", d,
          {11'h0, cur_m[VEC[v].ep], 1'b0, VEC[v].ok,
           VEC[v].ok ? (h ? 2'b01 : 2'b10) : 2'b11});
      cfg_wr(VEC[v].ep, 2, 16'h0007);
    end
    tick(3);
    chk("R5 irq low when nothing done", irq, 0);

    // R2 grant withheld, then one wait cycle
    cfg_wr(0, 0, 16'h080);
    usb_ep = 0; usb_dir = 0; usb_start = 1; tick(); usb_start = 0; tick();
    ram_gnt = 0; start = wr_n;
    usb_rx_valid = 1; usb_rx_data = 8'hA5; tick(); usb_rx_valid = 0;
    chk("R2 request raised", {ram_req, ram_we, 6'h0, ram_addr}, {2'b11, 6'h0, 10'h080});
    tick(2);
    chk("R2 held without grant", {ram_req, ram_addr}, {1'b1, 10'h080});
    ram_gnt = 1; ram_wait = 1; tick();
    chk("R2 held through wait", {ram_req, 8'(wr_n - start)}, {1'b1, 8'd0});
    ram_wait = 0; tick();
    chk("R2 completes after wait", {ram_req, mem[10'h080]}, {1'b0, 8'hA5});
    tick(2); usb_end = 1; usb_ok = 1; tick(); usb_end = 0; tick(4);
    cfg_wr(0, 2, 16'h0007);

    // R3 IN read of the byte just stored
    usb_ep = 0; usb_dir = 1; usb_start = 1; tick(); usb_start = 0; tick();
    usb_tx_req = 1; tick(); usb_tx_req = 0; tick();
    chk("R3 not yet valid", usb_tx_valid, 0);
    tick();
    chk("R3 tx byte", {usb_tx_valid, usb_tx_data}, {1'b1, 8'hA5});
    tick(2); usb_end = 1; usb_ok = 1; tick(); usb_end = 0; tick(4);
    cfg_wr(0, 2, 16'h0007);

    // R4 second byte while first ungranted
    ram_gnt = 0; start = wr_n;
    usb_ep = 3; usb_dir = 0; usb_start = 1; tick(); usb_start = 0; tick();
    usb_rx_valid = 1; usb_rx_data = 8'h11; tick();
    usb_rx_data = 8'h22; tick(); usb_rx_valid = 0; tick(2);
    ram_gnt = 1; tick(3);
    usb_end = 1; usb_ok = 1; tick(); usb_end = 0; tick(4);
    cfg_rd(3, 2, d); chk("R4 error flag set", d[3], 1);
    cfg_rd(3, 3, d); chk("R4 dropped byte not counted", d, 16'd1);
    chk("R4 single write", {8'(wr_n - start), mem[10'h200]}, {8'd1, 8'h11});
    cfg_wr(3, 2, 16'h000F);
    cfg_rd(3, 2, d); chk("R4 R10 clear error and release", d, 16'h0003);

    // R9 NAK when current half still CPU-owned
    pkt_out(3, 2, 1'b1, 9);
    start = wr_n;
    usb_ep = 3; usb_dir = 0; usb_start = 1; tick(); usb_start = 0;
    chk("R9 nak pulse", usb_nak, 1);
    usb_rx_valid = 1; usb_rx_data = 8'h77; tick(); usb_rx_valid = 0;
    chk("R9 nak single cycle", usb_nak, 0);
    tick(3);
    chk("R9 no RAM access", {ram_req, 8'(wr_n - start)}, 9'd0);
    cfg_wr(3, 2, 16'h0007);

    // R10 completion and clear-done in the same cycle
    usb_ep = 0; usb_dir = 0; usb_start = 1; tick(); usb_start = 0; tick();
    usb_rx_valid = 1; usb_rx_data = 8'h5A; tick(); usb_rx_valid = 0; tick(4);
    usb_end = 1; usb_ok = 1; tick(); usb_end = 0;
    cfg_addr = {2'd0, 3'd2}; cfg_wdata = 16'h0004; cfg_we = 1; tick(); cfg_we = 0;
    tick(3);
    cfg_rd(0, 2, d); chk("R10 done survives same-cycle clear", d[2], 1);
    chk("R5 irq raised", irq, 1);
    cfg_wr(0, 2, 16'h0007); tick(3);
    chk("R5 R10 irq cleared", irq, 0);
    cfg_rd(0, 2, d); chk("R10 released", d, 16'h0003);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule